// File: doc/BRIEF.md
# Pin Edge Interrupt Controller

This block watches a group of general-purpose pins and records, for each pin, that a qualifying edge has happened. Each pin has its own direction bit that picks whether rising or falling transitions count, and its own enable bit that decides whether the recorded event reaches the shared interrupt request line. The pin inputs are asynchronous to the block clock, so they pass through a synchronizer before an edge is detected. Edges are detected whether the pad drives the pin or receives it.

Software reaches three registers through a small bus: enable, edge direction and event flags. An event flag stays set until software writes a one to that bit. A parameter marks which bit positions exist. Positions that do not exist read as zero, ignore writes and never raise a flag. The interrupt line is a registered OR of all flags that are also enabled.

Top module: `pin_evt_irq`

## Requirements
- R1: After reset, the enable, direction and flag registers read 0x00, the read data is 0x00 and `irq` is 0.
- R2: With its direction bit at 1, a 0-to-1 transition on an implemented pin sets that pin's flag. The flag is set three clock edges after the pin value is first captured.
- R3: With its direction bit at 0, a 1-to-0 transition sets the flag. A transition in the other direction leaves the flag unchanged.
- R4: Writing the flag register (address 2) clears each flag whose write-data bit is 1. Flags whose write-data bit is 0 keep their value. No flag clears without such a write.
- R5: A flag sets whatever the state of its enable bit. `irq` is 1 only while at least one flag and its enable bit (address 0) are both 1.
- R6: `irq` follows the OR of enabled flags with exactly one clock edge of delay.
- R7: Bit positions cleared in `IMPL_MASK` read as 0 in every register, ignore writes and never set a flag.
- R8: If a new edge and a write-1-to-clear reach the same flag on the same clock edge, the flag ends up set.
- R9: A read with `rd_en` high returns on `rdata` at the next clock edge: enable at address 0, direction at address 1, flags at address 2, and 0x00 at address 3. Writes to address 1 load the direction register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pins | input | NUM_PINS | Asynchronous pin levels |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select |
| wdata | input | NUM_PINS | Write data |
| rdata | output | NUM_PINS | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that `addr`, `wr_en` and `wdata` are stable around each rising clock edge. They also assume that the internal event vector comes from synchronized pin levels, so it is never X after reset. The bench changes pins, strobes and data only on falling edges and holds each pin level for several clocks. As a result every transition passes cleanly through the synchronizer. The bench times the set-versus-clear collision by counting edges from the pin change, so that the write and the detected edge land on the same rising edge.

// File: rtl/pin_evt_pkg.sv
`timescale 1ns/1ps
package pin_evt_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_EN   = 2'd0,
    REG_DIR  = 2'd1,
    REG_FLAG = 2'd2,
    REG_RSVD = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pin_sync.sv
`timescale 1ns/1ps
module pin_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/edge_sel.sv
`timescale 1ns/1ps
module edge_sel #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] dir,
  output logic [W-1:0] evt
);
  logic [W-1:0] lvl_d;
  logic [W-1:0] rise;
  logic [W-1:0] fall;

  always_ff @(posedge clk) begin
    if (rst) lvl_d <= '0;
    else     lvl_d <= lvl;
  end

  always_comb begin
    rise = lvl & ~lvl_d;
    fall = ~lvl & lvl_d;
    evt  = (dir & rise) | (~dir & fall);
  end
endmodule

// File: rtl/flag_bank.sv
`timescale 1ns/1ps
module flag_bank #(
  parameter int           W    = 8,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] flags
);
  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= ((flags & ~clr_vec) | set_vec) & MASK;
  end
endmodule

// File: rtl/pin_evt_irq.sv
`timescale 1ns/1ps
module pin_evt_irq
  import pin_evt_pkg::*;
#(
  parameter int                  NUM_PINS    = 8,
  parameter int                  SYNC_STAGES = 2,
  parameter logic [NUM_PINS-1:0] IMPL_MASK   = '1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pins,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [NUM_PINS-1:0] wdata,
  output logic [NUM_PINS-1:0] rdata,
  output logic                irq
);
  logic [NUM_PINS-1:0] lvl_s;
  logic [NUM_PINS-1:0] evt;
  logic [NUM_PINS-1:0] en_q;
  logic [NUM_PINS-1:0] dir_q;
  logic [NUM_PINS-1:0] flag_q;
  logic [NUM_PINS-1:0] clr_vec;
  logic [NUM_PINS-1:0] rd_mux;
  reg_sel_e            sel;

  assign sel = reg_sel_e'(addr);

  pin_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pins), .dout(lvl_s)
  );

  edge_sel #(.W(NUM_PINS)) u_edge (
    .clk(clk), .rst(rst), .lvl(lvl_s), .dir(dir_q), .evt(evt)
  );

  assign clr_vec = (wr_en && sel == REG_FLAG) ? wdata : '0;

  flag_bank #(.W(NUM_PINS), .MASK(IMPL_MASK)) u_flags (
    .clk(clk), .rst(rst), .set_vec(evt & IMPL_MASK), .clr_vec(clr_vec), .flags(flag_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      dir_q <= '0;
    end else if (wr_en) begin
      if (sel == REG_EN)  en_q  <= wdata & IMPL_MASK;
      if (sel == REG_DIR) dir_q <= wdata & IMPL_MASK;
    end
  end

  always_comb begin
    unique case (sel)
      REG_EN:   rd_mux = en_q;
      REG_DIR:  rd_mux = dir_q;
      REG_FLAG: rd_mux = flag_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_mux;
      irq <= |(flag_q & en_q);
    end
  end
endmodule

// File: rtl/pin_evt_chk.sv
`timescale 1ns/1ps
module pin_evt_chk
  import pin_evt_pkg::*;
#(
  parameter int                  NUM_PINS  = 8,
  parameter logic [NUM_PINS-1:0] IMPL_MASK = '1
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic [ADDR_W-1:0]   addr,
  input logic [NUM_PINS-1:0] en_q,
  input logic [NUM_PINS-1:0] flag_q,
  input logic [NUM_PINS-1:0] evt,
  input logic                irq
);
  logic flag_wr;
  assign flag_wr = wr_en && (addr == REG_FLAG);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (flag_q == '0 && en_q == '0 && !irq)); // R1

  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|(flag_q & en_q)))); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    !flag_wr |=> ((flag_q & $past(flag_q)) == $past(flag_q))); // R4

  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (rst)
    |(evt & IMPL_MASK) |=> ((flag_q & $past(evt & IMPL_MASK)) == $past(evt & IMPL_MASK))); // R8

  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((flag_q | en_q) & ~IMPL_MASK) == '0); // R7
endmodule

bind pin_evt_irq pin_evt_chk #(.NUM_PINS(NUM_PINS), .IMPL_MASK(IMPL_MASK)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
  .en_q(en_q), .flag_q(flag_q), .evt(evt), .irq(irq)
);

// File: tb/sim_pin_evt_irq.sv
`timescale 1ns/1ps
module sim_pin_evt_irq;
  localparam int         N    = 8;
  localparam logic [7:0] MASK = 8'h7F;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pins = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  logic rd_d = 1'b0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #2.5 clk = ~clk;

  pin_evt_irq #(.NUM_PINS(N), .SYNC_STAGES(2), .IMPL_MASK(MASK)) u0 (
    .clk(clk), .rst(rst), .pins(pins), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always @(posedge clk) rd_d <= rd_en;

  // monitor: pop expected read values when data appears
  always @(negedge clk) begin
    if (rd_d && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        fails++;
        $display("FAIL %s rdata actual=%h expected=%h", t, rdata, e);
      end
    end
  end

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic reg_rd(input logic [1:0] a, input logic [7:0] e, input string t);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s irq actual=%b expected=%b", t, irq, e);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    // R1: reset state
    chk_irq(1'b0, "R1");
    reg_rd(2'd0, 8'h00, "R1");
    reg_rd(2'd1, 8'h00, "R1");
    reg_rd(2'd2, 8'h00, "R1");
    // R9: direction register write/read, reserved address
    reg_wr(2'd1, 8'h0F);
    reg_rd(2'd1, 8'h0F, "R9");
    reg_rd(2'd3, 8'h00, "R9");
    // R2/R3: rising on all pins, only pins 0..3 count
    pins = 8'hFF;
    idle(5);
    reg_rd(2'd2, 8'h0F, "R2");
    chk_irq(1'b0, "R5");
    // R3/R7: falling on all pins, pins 4..6 count, pin 7 unimplemented
    pins = 8'h00;
    idle(5);
    reg_rd(2'd2, 8'h7F, "R3");
    // R7: unimplemented enable bit ignores write
    reg_wr(2'd0, 8'hFF);
    reg_rd(2'd0, 8'h7F, "R7");
    idle(1);
    chk_irq(1'b1, "R5");
    // R4: write 0 leaves flags, write 1 clears selected
    reg_wr(2'd2, 8'h00);
    reg_rd(2'd2, 8'h7F, "R4");
    reg_wr(2'd2, 8'h0F);
    reg_rd(2'd2, 8'h70, "R4");
    reg_wr(2'd2, 8'h70);
    reg_rd(2'd2, 8'h00, "R4");
    idle(1);
    chk_irq(1'b0, "R4");
    // R6: exact irq latency on pin 0 rising
    pins = 8'h01;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_irq(1'b0, "R6");
    @(negedge clk);
    chk_irq(1'b1, "R6");
    reg_rd(2'd2, 8'h01, "R2");
    // R8: clear and new edge on the same clock edge
    reg_wr(2'd2, 8'h01);
    pins = 8'h00;
    idle(4);
    reg_rd(2'd2, 8'h00, "R8");
    pins = 8'h01;
    repeat (2) @(posedge clk);
    @(negedge clk);
    reg_wr(2'd2, 8'h01);
    reg_rd(2'd2, 8'h01, "R8");
    // R5: disabling masks irq while flag stays
    reg_wr(2'd0, 8'h00);
    idle(1);
    chk_irq(1'b0, "R5");
    reg_rd(2'd2, 8'h01, "R5");
    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #20000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule